// File: doc/BRIEF.md
# Serial-Loaded Phase Accumulator Core

This block is the digital core of a direct digital synthesizer that is programmed over a three-wire serial link. A host moves a 40-bit frame in one bit at a time. Each bit is taken on a rising edge of the serial bit clock, least significant bit first. A rising edge on a separate update line then commits the frame to the working registers. Until that commit, bits being shifted in have no effect on the output.

Once committed, the low 32 bits of the frame are a frequency tuning word and the high 8 bits are a control byte. The core adds the tuning word to a 32-bit phase accumulator on every sample clock. The output frequency is therefore tuning word × reference ÷ 2^32. Control bits 7:3 give a coarse phase offset in steps of 11.25 degrees, 32 steps per cycle, and this offset is added at the top of the accumulator. Control bit 0 asks for the reference multiplier and is reported on a status pin.

The outputs are a truncated phase word, for a later sine lookup, and the phase MSB as a square wave. All three serial pins are asynchronous. They are synchronized into the sample-clock domain and edge-detected there.

Top module: `dds_phase_core`

## Requirements
- R1: Bit clock and data are sampled in the sample-clock domain. On each rising edge of the bit clock the 40-bit frame register shifts right and the data bit enters at bit 39. As a result, the first bit received ends up at bit 0. Falling edges and steady levels do not shift the frame.
- R2: Frame bits 31:0 form the tuning word and frame bits 39:32 form the control byte. The first bit sent is tuning-word bit 0.
- R3: Only a rising edge of the update line copies the frame into the active tuning-word and control registers. Shifting in a new frame without an update leaves the output behaviour unchanged.
- R4: `mult_en_o` equals bit 0 of the active control byte.
- R5: The 32-bit accumulator adds the active tuning word on every clock, modulo 2^32.
- R6: The output phase is the accumulator plus (control bits 7:3) shifted left by 27, modulo 2^32. For example, offset 8 is a quarter cycle, and offset 31 added to 0x80000000 wraps.
- R7: `phase_o` is bits 31:20 of the output phase and `square_o` is bit 31. Both are registered from the accumulator value held before the clock edge.
- R8: A synchronous active-high reset clears the accumulator, the frame, the active registers, the synchronizers and all outputs. All outputs read zero until the first update.
- R9: Serial pins pass through a two-stage synchronizer. A rising edge driven between clock edges k and k+1 reaches the active registers at clock edge k+3, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial bit clock |
| ser_dat_i | input | 1 | Asynchronous serial data, LSB first |
| ser_upd_i | input | 1 | Asynchronous update strobe, commits on rising edge |
| phase_o | output | 12 | Truncated output phase word |
| square_o | output | 1 | Phase MSB as square wave |
| mult_en_o | output | 1 | Reference multiplier request flag |

## Verification
The embedded properties check the following on every cycle:
- the frame holds still without a bit-clock rising edge;
- the active registers change only on an update edge, and then take the frame exactly;
- the accumulator advances by the tuning word;
- detected edges last one cycle.

Only the bench scenarios can show the rest:
- LSB-first bit ordering and field split;
- offset arithmetic and wrap at the top bits;
- the exact three-edge synchronizer latency;
- that a frame shifted in without an update leaves the output rate alone.

The bench covers these with a behavioural reference model compared every clock and with targeted arithmetic checks.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic bclk;
    logic bdat;
    logic bupd;
  } ser_pins_t;
endpackage

// File: rtl/dds_sync.sv
module dds_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[s] <= '0;
        else       stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dds_frame_rx.sv
module dds_frame_rx
  import dds_pkg::*;
#(
  parameter int FTW_W       = 32,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_upd_i,
  output logic [FTW_W-1:0]  ftw_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int FRM_W = FTW_W + CTRL_W;
  localparam int PIN_W = $bits(ser_pins_t);

  ser_pins_t         raw, syn, prev_q;
  logic [PIN_W-1:0]  syn_bits;
  logic [FRM_W-1:0]  frame_q;
  logic              clk_rise, upd_rise;

  assign raw = '{bclk: ser_clk_i, bdat: ser_dat_i, bupd: ser_upd_i};

  dds_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw),
    .q_o   (syn_bits)
  );

  assign syn = ser_pins_t'(syn_bits);

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= syn;
  end

  assign clk_rise = syn.bclk & ~prev_q.bclk;
  assign upd_rise = syn.bupd & ~prev_q.bupd;

  always_ff @(posedge clk_i) begin
    if (rst_i)         frame_q <= '0;
    else if (clk_rise) frame_q <= {syn.bdat, frame_q[FRM_W-1:1]};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ftw_q  <= '0;
      ctrl_q <= '0;
    end else if (upd_rise) begin
      ftw_q  <= frame_q[FTW_W-1:0];
      ctrl_q <= frame_q[FRM_W-1 -: CTRL_W];
    end
  end

  p_shift_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !clk_rise |=> $stable(frame_q));
  p_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_rise |=> (ftw_q == $past(frame_q[FTW_W-1:0]) &&
                  ctrl_q == $past(frame_q[FRM_W-1 -: CTRL_W])));
  p_keep_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !upd_rise |=> ($stable(ftw_q) && $stable(ctrl_q)));
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_rise |=> !clk_rise);
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 5,
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OUT_W-1:0] phase_o,
  output logic             square_o
);
  localparam int OFS_POS = ACC_W - OFS_W;

  logic [ACC_W-1:0] acc_q, ph_w;

  assign ph_w = acc_q + (ACC_W'(ofs_i) << OFS_POS);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q    <= '0;
      phase_o  <= '0;
      square_o <= 1'b0;
    end else begin
      acc_q    <= acc_q + ftw_i;
      phase_o  <= ph_w[ACC_W-1 -: OUT_W];
      square_o <= ph_w[ACC_W-1];
    end
  end

  p_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (acc_q == $past(acc_q) + $past(ftw_i)));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int ACC_W       = 32,
  parameter int CTRL_W      = 8,
  parameter int OFS_W       = 5,
  parameter int OUT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_upd_i,
  output logic [OUT_W-1:0] phase_o,
  output logic             square_o,
  output logic             mult_en_o
);
  localparam int OFS_LSB = CTRL_W - OFS_W;

  logic [ACC_W-1:0]  ftw;
  logic [CTRL_W-1:0] ctrl;

  dds_frame_rx #(.FTW_W(ACC_W), .CTRL_W(CTRL_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .ser_upd_i (ser_upd_i),
    .ftw_q     (ftw),
    .ctrl_q    (ctrl)
  );

  dds_phase_gen #(.ACC_W(ACC_W), .OFS_W(OFS_W), .OUT_W(OUT_W)) u_gen (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ftw_i    (ftw),
    .ofs_i    (ctrl[CTRL_W-1 -: OFS_W]),
    .phase_o  (phase_o),
    .square_o (square_o)
  );

  assign mult_en_o = ctrl[0];

  initial begin
    if (OFS_LSB < 1) $error("control byte too narrow for flag and offset");
  end
endmodule

// File: tb/dds_phase_core_test.sv
module dds_phase_core_test;
  logic clk = 0, rst = 1;
  logic s_clk = 0, s_dat = 0, s_upd = 0;
  logic [11:0] phase;
  logic sq, mult;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dds_phase_core uut (.clk_i(clk), .rst_i(rst), .ser_clk_i(s_clk), .ser_dat_i(s_dat),
    .ser_upd_i(s_upd), .phase_o(phase), .square_o(sq), .mult_en_o(mult));

  // behavioural reference model
  logic [2:0]  h1, h2, h3;  // {clk,dat,upd} sampled 1,2,3 edges ago
  logic [39:0] m_frame;
  logic [31:0] m_tw, m_acc, m_ph;
  logic [7:0]  m_ctrl;
  logic [11:0] m_phase;
  logic        m_sq;

  always @(posedge clk) begin
    if (rst) begin
      h1 = 0; h2 = 0; h3 = 0; m_frame = 0; m_tw = 0; m_ctrl = 0;
      m_acc = 0; m_phase = 0; m_sq = 0;
    end else begin
      m_ph    = m_acc + ({27'd0, m_ctrl[7:3]} << 27);
      m_phase = m_ph[31:20];
      m_sq    = m_ph[31];
      m_acc   = m_acc + m_tw;
      if (h2[0] && !h3[0]) begin m_tw = m_frame[31:0]; m_ctrl = m_frame[39:32]; end
      if (h2[2] && !h3[2]) m_frame = {h2[1], m_frame[39:1]};
      h3 = h2; h2 = h1; h1 = {s_clk, s_dat, s_upd};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R5 R6 R7 phase vs model", {20'd0, phase}, {20'd0, m_phase});
    chk("R7 square vs model", {31'd0, sq}, {31'd0, m_sq});
    chk("R4 mult flag vs model", {31'd0, mult}, {31'd0, m_ctrl[0]});
  end

  task automatic send_frame(input logic [31:0] tw, input logic [7:0] c);
    logic [39:0] f = {c, tw};
    for (int i = 0; i < 40; i++) begin
      s_dat = f[i];
      repeat (3) @(negedge clk);
      s_clk = 1;
      repeat (3) @(negedge clk);
      s_clk = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic update();
    s_upd = 1;
    repeat (4) @(negedge clk);
    s_upd = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic step_check(input string req, input logic [11:0] step);
    logic [11:0] a;
    a = phase;
    @(negedge clk);
    chk(req, {20'd0, phase - a}, {20'd0, step});
  endtask

  initial begin
    logic [11:0] p0, p1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset phase", {20'd0, phase}, 0);
    chk("R8 reset square", {31'd0, sq}, 0);
    chk("R8 reset mult", {31'd0, mult}, 0);

    // shifting without update: still silent
    send_frame(32'h0030_0000, 8'h00);
    repeat (5) @(negedge clk);
    chk("R3 no commit without update", {20'd0, phase}, 0);

    update();
    step_check("R1 R2 R5 step of 3", 12'd3);
    chk("R4 mult low", {31'd0, mult}, 0);

    // new frame without update keeps old rate
    send_frame(32'h0070_0000, 8'h01);
    step_check("R3 old rate kept", 12'd3);
    chk("R3 mult unchanged", {31'd0, mult}, 0);

    // R9 latency: update edge reaches registers at third clock edge
    s_upd = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet at edge k+2", {31'd0, mult}, 0);
    @(negedge clk);
    chk("R9 committed at edge k+3", {31'd0, mult}, 1);
    repeat (3) @(negedge clk);
    s_upd = 0;
    repeat (6) @(negedge clk);
    step_check("R5 new step of 7", 12'd7);

    // offset arithmetic with frozen accumulator
    do_reset();
    send_frame(32'h0, 8'd8 << 3);
    update();
    chk("R6 quarter-cycle offset", {20'd0, phase}, 32'h400);
    send_frame(32'h0, 8'd31 << 3);
    update();
    chk("R6 max offset", {20'd0, phase}, 32'hF80);
    chk("R7 square high", {31'd0, sq}, 1);

    // wrap: half-cycle step plus max offset
    send_frame(32'h8000_0000, (8'd31 << 3) | 8'd1);
    update();
    p0 = phase;
    @(negedge clk);
    p1 = phase;
    chk("R6 wrap pair", {20'd0, p0 ^ p1}, 32'h800);
    chk("R6 wrap value", {31'd0, (p0 == 12'hF80) || (p0 == 12'h780)}, 1);

    // all-ones step counts down
    send_frame(32'hFFFF_FFFF, 8'h00);
    update();
    repeat (3) @(negedge clk);

    // mid-run reset
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R8 mid-run reset phase", {20'd0, phase}, 0);
    chk("R8 mid-run reset mult", {31'd0, mult}, 0);
    rst = 0;
    repeat (5) @(negedge clk);
    chk("R8 silent after reset", {20'd0, phase}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule